// File: doc/BRIEF.md
# Timer Interrupt Flag Bank with Mode-Selected Compare Channels

This block pairs a free-running up-counter with a three-bit interrupt flag register. The flags record a counter overflow and two compare matches. In the split mode the counter is half-width and two independent compare bytes each drive their own flag. In the wide mode the counter is full-width and the two compare bytes join into one value, with the high byte on `cmp_hi_i` and the low byte on `cmp_lo_i`. That joined match reports through the A flag only. The two capture modes model the compare bytes being taken over as capture storage. A flag whose byte holds captured data is then held off.

Software clears a flag by writing a one to its bit. An interrupt controller clears a flag by pulsing the acknowledge line for that source when it services the vector. An interrupt request for a source is raised when the global enable, the enable for that source and its flag are all set. A synchronous clear input restarts the counter and empties the flag register.

Top module: `tmr_irq_flags`

## Requirements
- R1: On a cycle with `step_i` high the count advances by one. It wraps to zero after 2^HALF_W-1 when `mode_i[0]`=0 (narrow) and after 2^(2*HALF_W)-1 when `mode_i[0]`=1 (wide). In narrow modes the upper half of `count_o` reads zero after any step. Without `step_i` the count holds.
- R2: Flag bit 0 (overflow) sets on the same edge at which a step wraps the count to zero.
- R3: Flag bit 2 (compare B) sets on the edge at which a step brings the count to `cmp_hi_i`. This applies in modes 2'b00 (split) and 2'b10 (narrow capture).
- R4: Flag bit 1 (compare A) sets on the edge at which a step brings the count to `cmp_lo_i` in mode 2'b00. In mode 2'b01 (wide compare) it instead sets when the count reaches {`cmp_hi_i`,`cmp_lo_i`}.
- R5: Flag bit 2 never sets in modes 2'b01 and 2'b11 (wide capture).
- R6: Flag bit 1 never sets in modes 2'b10 and 2'b11.
- R7: A write (`wr_en_i`) with a one in bit k clears flag k. A zero in bit k leaves flag k unchanged.
- R8: A one-cycle pulse on `ack_i[k]` clears flag k at the next edge.
- R9: When a set event for flag k and a clear (write-one or acknowledge) fall in the same cycle, flag k ends set.
- R10: `irq_o[k]` is high exactly when `gie_i`, `ien_i[k]` and flag k are all high.
- R11: Bits of `flags_o` above bit 2 always read zero.
- R12: After reset, and on the edge after `clr_i` is high, the count and all flags are zero. `clr_i` overrides any step, set, write or acknowledge in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous restart of count and flags |
| step_i | input | 1 | Count enable, one step per high cycle |
| mode_i | input | 2 | Bit 0 wide counter, bit 1 capture use of compare bytes |
| cmp_lo_i | input | HALF_W | Compare A byte, low byte in wide mode |
| cmp_hi_i | input | HALF_W | Compare B byte, high byte in wide mode |
| wr_en_i | input | 1 | Flag register write strobe |
| wr_data_i | input | REG_W | Write data, ones clear flags |
| ien_i | input | 3 | Per-source interrupt enables |
| gie_i | input | 1 | Global interrupt enable |
| ack_i | input | 3 | Per-source vector-serviced pulses |
| count_o | output | 2*HALF_W | Current count |
| flags_o | output | REG_W | Flag register contents |
| irq_o | output | 3 | Interrupt requests |

## Verification
The bench builds the block with HALF_W=4. The narrow counter then wraps every 16 steps and the wide counter every 256 steps. This makes every compare value and every wrap reachable within a short run in all four modes. The bench sweeps every low compare byte, paired with a spread of high bytes, under pseudo-random steps, writes, acknowledges and enables. An arithmetic model predicts the count, each flag and each request on every cycle. Directed sequences then force a set event to collide with a clear, write zero bits, and restart the block mid-run.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  typedef enum logic [1:0] {
    TM_SPLIT      = 2'b00,
    TM_WIDE       = 2'b01,
    TM_CAP_NARROW = 2'b10,
    TM_CAP_WIDE   = 2'b11
  } tmr_mode_e;

  localparam int unsigned NSRC    = 3;
  localparam int unsigned FB_OVF  = 0;
  localparam int unsigned FB_CMPA = 1;
  localparam int unsigned FB_CMPB = 2;
endpackage

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int unsigned HALF_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  step,
  input  logic                  wide,
  output logic [2*HALF_W-1:0]   cnt_q,
  output logic [2*HALF_W-1:0]   nxt_o,
  output logic                  wrap_o
);
  localparam int unsigned CW = 2 * HALF_W;

  logic [CW-1:0] lim;
  logic [CW-1:0] cur;
  logic          at_lim;
  logic [CW-1:0] cnt_d;

  always_comb begin
    lim    = wide ? {CW{1'b1}} : {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
    cur    = cnt_q & lim;
    at_lim = (cur == lim);
    nxt_o  = at_lim ? '0 : cur + 1'b1;
    wrap_o = step & ~clr & at_lim;
    if (clr)       cnt_d = '0;
    else if (step) cnt_d = nxt_o;
    else           cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R1
  narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && !wide) |=> (cnt_q[CW-1:HALF_W] == '0));

  // R1
  full_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && cnt_q == {CW{1'b1}}) |=> (cnt_q == '0));

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clr) |=> $stable(cnt_q));

  // R12
  restart_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/tmr_match_unit.sv
module tmr_match_unit #(
  parameter int unsigned HALF_W = 8
) (
  input  logic                  wide,
  input  logic                  cap,
  input  logic                  step,
  input  logic                  clr,
  input  logic [2*HALF_W-1:0]   nxt,
  input  logic [HALF_W-1:0]     cmp_lo,
  input  logic [HALF_W-1:0]     cmp_hi,
  output logic                  set_a,
  output logic                  set_b
);
  logic live;
  logic hit_a;
  logic hit_b;

  always_comb begin
    live  = step & ~clr;
    hit_a = wide ? (nxt == {cmp_hi, cmp_lo})
                 : (nxt == {{HALF_W{1'b0}}, cmp_lo});
    hit_b = (nxt == {{HALF_W{1'b0}}, cmp_hi});
    set_a = live & ~cap & hit_a;
    set_b = live & ~wide & hit_b;
  end
endmodule

// File: rtl/tmr_flag_bank.sv
module tmr_flag_bank #(
  parameter int unsigned NS = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [NS-1:0] set,
  input  logic          wr_en,
  input  logic [NS-1:0] wr_bits,
  input  logic [NS-1:0] ack,
  input  logic [NS-1:0] ien,
  input  logic          gie,
  output logic [NS-1:0] flag_q,
  output logic [NS-1:0] irq
);
  logic [NS-1:0] flag_d;

  for (genvar k = 0; k < NS; k++) begin : g_bit
    logic drop;

    always_comb begin
      drop = (wr_en & wr_bits[k]) | ack[k];
      if (clr) flag_d[k] = 1'b0;
      else     flag_d[k] = set[k] | (flag_q[k] & ~drop);
    end

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set[k] && !clr) |=> flag_q[k]);

    // R7
    write_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_bits[k] && !set[k]) |=> !flag_q[k]);

    // R8
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack[k] && !set[k]) |=> !flag_q[k]);

    // R7
    zero_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[k] && !clr && !ack[k] && !(wr_en && wr_bits[k])) |=> flag_q[k]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  always_comb begin
    irq = flag_q & ien & {NS{gie}};
  end

  // R12
  restart_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (flag_q == '0));
endmodule

// File: rtl/tmr_irq_flags.sv
module tmr_irq_flags
  import tmr_irq_pkg::*;
#(
  parameter int unsigned HALF_W = 8,
  parameter int unsigned REG_W  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr_i,
  input  logic                  step_i,
  input  logic [1:0]            mode_i,
  input  logic [HALF_W-1:0]     cmp_lo_i,
  input  logic [HALF_W-1:0]     cmp_hi_i,
  input  logic                  wr_en_i,
  input  logic [REG_W-1:0]      wr_data_i,
  input  logic [NSRC-1:0]       ien_i,
  input  logic                  gie_i,
  input  logic [NSRC-1:0]       ack_i,
  output logic [2*HALF_W-1:0]   count_o,
  output logic [REG_W-1:0]      flags_o,
  output logic [NSRC-1:0]       irq_o
);
  localparam int unsigned CW = 2 * HALF_W;

  tmr_mode_e     mode_e;
  logic          wide;
  logic          cap;
  logic [CW-1:0] nxt;
  logic          wrap;
  logic          set_a;
  logic          set_b;
  logic [NSRC-1:0] set_vec;
  logic [NSRC-1:0] flag_q;
  logic          unused_wr;

  always_comb begin
    mode_e = tmr_mode_e'(mode_i);
    wide   = (mode_e == TM_WIDE) || (mode_e == TM_CAP_WIDE);
    cap    = (mode_e == TM_CAP_NARROW) || (mode_e == TM_CAP_WIDE);
    set_vec          = '0;
    set_vec[FB_OVF]  = wrap;
    set_vec[FB_CMPA] = set_a;
    set_vec[FB_CMPB] = set_b;
    flags_o          = '0;
    flags_o[NSRC-1:0] = flag_q;
  end

  assign unused_wr = ^wr_data_i[REG_W-1:NSRC];

  tmr_count_core #(.HALF_W(HALF_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr_i),
    .step   (step_i),
    .wide   (wide),
    .cnt_q  (count_o),
    .nxt_o  (nxt),
    .wrap_o (wrap)
  );

  tmr_match_unit #(.HALF_W(HALF_W)) u_match (
    .wide   (wide),
    .cap    (cap),
    .step   (step_i),
    .clr    (clr_i),
    .nxt    (nxt),
    .cmp_lo (cmp_lo_i),
    .cmp_hi (cmp_hi_i),
    .set_a  (set_a),
    .set_b  (set_b)
  );

  tmr_flag_bank #(.NS(NSRC)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr_i),
    .set     (set_vec),
    .wr_en   (wr_en_i),
    .wr_bits (wr_data_i[NSRC-1:0]),
    .ack     (ack_i),
    .ien     (ien_i),
    .gie     (gie_i),
    .flag_q  (flag_q),
    .irq     (irq_o)
  );

  // R5
  b_held_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i[0] && !flags_o[FB_CMPB]) |=> !flags_o[FB_CMPB]);

  // R6
  a_held_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i[1] && !flags_o[FB_CMPA]) |=> !flags_o[FB_CMPA]);

  // R2
  wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !clr_i && count_o == {CW{1'b1}}) |=> flags_o[FB_OVF]);
endmodule

// File: tb/sim_tmr_irq_flags.sv
module sim_tmr_irq_flags;
  localparam int unsigned HW = 4;
  localparam int unsigned RW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clr_i = 1'b0;
  logic          step_i = 1'b0;
  logic [1:0]    mode_i = 2'b00;
  logic [HW-1:0] cmp_lo_i = '0;
  logic [HW-1:0] cmp_hi_i = '0;
  logic          wr_en_i = 1'b0;
  logic [RW-1:0] wr_data_i = '0;
  logic [2:0]    ien_i = '0;
  logic          gie_i = 1'b0;
  logic [2:0]    ack_i = '0;
  logic [2*HW-1:0] count_o;
  logic [RW-1:0] flags_o;
  logic [2:0]    irq_o;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int m_cnt = 0;
  logic [2:0] m_flg = '0;
  logic [15:0] lf = 16'hACE1;

  always #10 clk = ~clk;

  tmr_irq_flags #(.HALF_W(HW), .REG_W(RW)) u0 (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .step_i(step_i), .mode_i(mode_i),
    .cmp_lo_i(cmp_lo_i), .cmp_hi_i(cmp_hi_i), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .ien_i(ien_i), .gie_i(gie_i), .ack_i(ack_i),
    .count_o(count_o), .flags_o(flags_o), .irq_o(irq_o)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] lfsr(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  // One clock: predict, clock, compare. Inputs are already set at a falling edge.
  task automatic tick();
    int lim, low, nxt;
    logic [2:0] setv, drop;
    lim = mode_i[0] ? 255 : 15;
    low = m_cnt & lim;
    nxt = (low == lim) ? 0 : low + 1;
    setv = '0;
    if (step_i && !clr_i) begin
      setv[0] = (low == lim);
      if (mode_i == 2'b00) setv[1] = (nxt == int'(cmp_lo_i));
      if (mode_i == 2'b01) setv[1] = (nxt == int'(cmp_hi_i) * 16 + int'(cmp_lo_i));
      if (!mode_i[0])      setv[2] = (nxt == int'(cmp_hi_i));
    end
    drop = (wr_en_i ? wr_data_i[2:0] : 3'b000) | ack_i;
    if (clr_i) begin
      m_cnt = 0;
      m_flg = '0;
    end else begin
      if (step_i) m_cnt = nxt;
      m_flg = (m_flg & ~drop) | setv;
    end
    @(posedge clk);
    @(negedge clk);
    chk("R1 count", int'(count_o), m_cnt);
    chk("R2 overflow flag", int'(flags_o[0]), int'(m_flg[0]));
    chk(mode_i[1] ? "R6 A held off" : "R4 compare A", int'(flags_o[1]), int'(m_flg[1]));
    chk(mode_i[0] ? "R5 B held off" : "R3 compare B", int'(flags_o[2]), int'(m_flg[2]));
    chk("R11 upper bits", int'(flags_o[RW-1:3]), 0);
    chk("R10 irq", int'(irq_o), int'(m_flg & ien_i & {3{gie_i}}));
  endtask

  task automatic idle_inputs();
    clr_i = 0; step_i = 0; wr_en_i = 0; wr_data_i = '0; ack_i = '0;
  endtask

  task automatic restart_to(input int n);
    idle_inputs();
    clr_i = 1;
    tick();
    clr_i = 0;
    step_i = 1;
    for (int i = 0; i < n; i++) tick();
    step_i = 0;
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R12 reset state
    chk("R12 reset count", int'(count_o), 0);
    chk("R12 reset flags", int'(flags_o), 0);
    chk("R12 reset irq", int'(irq_o), 0);
    rst_n = 1;
    @(negedge clk);

    // Sweep: all modes, every low compare byte, spread of high bytes
    for (int md = 0; md < 4; md++) begin
      mode_i = md[1:0];
      for (int k = 0; k < 16; k++) begin
        cmp_lo_i = k[3:0];
        cmp_hi_i = 4'((k * 7 + md) & 15);
        for (int c = 0; c < (md[0] ? 48 : 24); c++) begin
          lf = lfsr(lf);
          idle_inputs();
          step_i    = (lf[1:0] != 2'b00);
          wr_en_i   = (lf[5:3] == 3'b000);
          wr_data_i = {lf[15:11], lf[8:6]};
          ack_i     = (lf[10:9] == 2'b00) ? lf[14:12] : 3'b000;
          ien_i     = lf[9:7];
          gie_i     = lf[2];
          clr_i     = (lf[15:6] == 10'h3FF);
          tick();
        end
      end
    end

    // R9: set collides with write-one and with acknowledge
    mode_i = 2'b00; cmp_hi_i = 4'd5; cmp_lo_i = 4'd5; gie_i = 1; ien_i = 3'b111;
    restart_to(4);
    step_i = 1; wr_en_i = 1; wr_data_i = 8'h06; ack_i = 3'b110;
    tick();
    idle_inputs();
    chk("R9 set beats clear B", int'(flags_o[2]), 1);
    chk("R9 set beats clear A", int'(flags_o[1]), 1);

    // R7: zero bits leave flags, one bits clear
    wr_en_i = 1; wr_data_i = 8'hF9;
    tick();
    chk("R7 zero-write keeps flags", int'(flags_o[2:0]), 3'b110);
    wr_data_i = 8'h04;
    tick();
    chk("R7 write-one clears B", int'(flags_o[2:0]), 3'b010);
    idle_inputs();

    // R8: acknowledge pulse clears only its source
    ack_i = 3'b010;
    tick();
    idle_inputs();
    chk("R8 ack clears A", int'(flags_o[2:0]), 3'b000);

    // R2 and R1: narrow wrap
    restart_to(15);
    step_i = 1;
    tick();
    idle_inputs();
    chk("R2 narrow wrap flag", int'(flags_o[0]), 1);
    chk("R1 narrow wrap count", int'(count_o), 0);

    // R4: wide joined compare at 0x35
    mode_i = 2'b01; cmp_hi_i = 4'd3; cmp_lo_i = 4'd5;
    restart_to(53);
    chk("R4 wide joined match", int'(flags_o[2:0]), 3'b010);
    chk("R5 B off in wide", int'(flags_o[2]), 0);

    // R6 and R3 in narrow capture
    mode_i = 2'b10; cmp_hi_i = 4'd5; cmp_lo_i = 4'd5;
    restart_to(5);
    chk("R3 B in narrow capture", int'(flags_o[2]), 1);
    chk("R6 A off in capture", int'(flags_o[1]), 0);

    // R12: restart overrides set and clears all
    restart_to(15);
    step_i = 1; clr_i = 1;
    tick();
    idle_inputs();
    chk("R12 clear overrides", int'(flags_o), 0);
    chk("R12 clear count", int'(count_o), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule